// File: doc/BRIEF.md
# Split-Phase SCL Timing Generator

This block sets the clock timing for a two-wire serial bus master. From a fast functional clock it produces the SCL level. It also produces three single-cycle strobes that the bus engine uses to decide when it moves SDA, when it samples SDA, and when a new bit period begins. The low phase and the high phase of SCL are sized by two separate 16-bit counts held in one 32-bit configuration word. This lets the duty cycle be asymmetric. Each phase lasts eight functional clocks per count unit plus one unit. A full period is therefore `8 * (low + 1 + high + 1)` clocks, and the fastest setting, with both counts zero, gives 16 clocks.

The engine controls the generator with a single `run` level. While `run` is low, SCL rests high and every internal count is cleared. When `run` rises, a fresh period starts with its low phase. The configuration word is captured only at the first cycle of each period, so software may rewrite it at any time without tearing the current bit.

Top module: `scl_phase_gen`

## Requirements
- R1: While `rst_n` is low, and in every cycle after a clock edge that samples `run` low, `scl_o` is 1 and `period_o`, `low_mid_o` and `high_mid_o` are all 0.
- R2: In the cycle after a clock edge that first samples `run` high from the stopped state, `scl_o` is 0 and `period_o` is 1.
- R3: The low phase (`scl_o` = 0) lasts exactly `8 * (L + 1)` cycles, where L is `div_cfg[15:0]`.
- R4: The high phase (`scl_o` = 1 while running) lasts exactly `8 * (H + 1)` cycles, where H is `div_cfg[31:16]`. A full period is therefore `8 * (L + H + 2)` cycles, or 16 cycles when both fields are zero.
- R5: `period_o` pulses for one cycle on the first low cycle of every period and at no other time.
- R6: `high_mid_o` pulses exactly once per high phase, at offset `4 * (H + 1)`, where offset 0 is the first high cycle.
- R7: `low_mid_o` pulses exactly once per low phase, at offset `4 * (L + 1)`, where offset 0 is the first low cycle.
- R8: `div_cfg` is captured only at the start of a period. A change made during a period leaves that period's timing untouched and applies from the next period.
- R9: Dropping `run` in the middle of a period returns `scl_o` high on the next cycle and discards the partial count. A later restart begins with a full low phase timed by the `div_cfg` value present at the restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Engine enable; low stops and clears the generator |
| div_cfg | input | 32 | High-phase count in [31:16], low-phase count in [15:0] |
| scl_o | output | 1 | SCL level to drive (1 = released high) |
| period_o | output | 1 | One-cycle pulse on the first low cycle of a period |
| low_mid_o | output | 1 | One-cycle pulse in the middle of the low phase (SDA update point) |
| high_mid_o | output | 1 | One-cycle pulse in the middle of the high phase (SDA sample point) |

## Verification
The bench first runs the fastest setting, with both fields zero, to pin down the 16-cycle floor and the mid-phase offsets at their smallest. It then runs one setting where high exceeds low and another where low exceeds high. A swap of the two fields, or an off-by-one in either phase, shows up as a shifted rise or strobe. A mid-period rewrite of the configuration tells apart a design that shadows the word at the period boundary from one that reads it live. An abort in the low phase followed by a restart with a different word shows that stopping clears the count and that the restart samples the new word. A long asymmetric setting exercises the wide count path.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_div_hold.sv
// Shadow copy of the two phase counts, refreshed only on a period boundary.
module scl_div_hold #(
  parameter int FIELD_W = 16,
  parameter int NFIELD  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [NFIELD*FIELD_W-1:0] cfg,
  output logic [NFIELD*FIELD_W-1:0] held
);
  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)
        held[g*FIELD_W +: FIELD_W] <= '0;
      else if (load)
        held[g*FIELD_W +: FIELD_W] <= cfg[g*FIELD_W +: FIELD_W];
    end
  end
endmodule

// File: rtl/scl_phase_fsm.sv
// Phase sequencer: one counter, reloaded at each phase change.
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int FIELD_W  = 16,
  parameter int PRE_LOG2 = 3,
  localparam int CNT_W   = FIELD_W + PRE_LOG2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [FIELD_W-1:0] lo_cnt,
  input  logic [FIELD_W-1:0] hi_cnt,
  output scl_phase_e         phase,
  output logic [CNT_W-1:0]   cnt,
  output logic               load_o
);
  logic [CNT_W-1:0] lo_last, hi_last;
  logic             lo_end, hi_end;

  // Last index of a phase is count*2^P + (2^P - 1).
  assign lo_last = {lo_cnt, {PRE_LOG2{1'b1}}};
  assign hi_last = {hi_cnt, {PRE_LOG2{1'b1}}};
  assign lo_end  = (phase == PH_LOW)  && (cnt == lo_last);
  assign hi_end  = (phase == PH_HIGH) && (cnt == hi_last);

  // Capture new counts when a period is about to begin.
  assign load_o = run && ((phase == PH_IDLE) || hi_end);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phase <= PH_LOW;
          cnt   <= '0;
        end
        PH_LOW: begin
          if (lo_end) begin
            phase <= PH_HIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (hi_end) begin
            phase <= PH_LOW;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_gen_pkg::*;
#(
  parameter int FIELD_W  = 16,
  parameter int PRE_LOG2 = 3,
  localparam int CFG_W   = 2 * FIELD_W,
  localparam int CNT_W   = FIELD_W + PRE_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CFG_W-1:0] div_cfg,
  output logic             scl_o,
  output logic             period_o,
  output logic             low_mid_o,
  output logic             high_mid_o
);
  logic [CFG_W-1:0]   held;
  logic [FIELD_W-1:0] lo_cnt, hi_cnt;
  logic [CNT_W-1:0]   cnt, lo_mid, hi_mid;
  logic               load;
  scl_phase_e         phase;

  scl_div_hold #(.FIELD_W(FIELD_W), .NFIELD(2)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .cfg   (div_cfg),
    .held  (held)
  );

  // Field order matters to the engine: high count on top, low below.
  assign lo_cnt = held[FIELD_W-1:0];
  assign hi_cnt = held[CFG_W-1:FIELD_W];

  scl_phase_fsm #(.FIELD_W(FIELD_W), .PRE_LOG2(PRE_LOG2)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .lo_cnt (lo_cnt),
    .hi_cnt (hi_cnt),
    .phase  (phase),
    .cnt    (cnt),
    .load_o (load)
  );

  // Middle of a phase: (count + 1) * 2^(P-1).
  assign lo_mid = CNT_W'({1'b0, lo_cnt} + (FIELD_W+1)'(1)) << (PRE_LOG2 - 1);
  assign hi_mid = CNT_W'({1'b0, hi_cnt} + (FIELD_W+1)'(1)) << (PRE_LOG2 - 1);

  assign scl_o      = (phase != PH_LOW);
  assign period_o   = (phase == PH_LOW)  && (cnt == '0);
  assign low_mid_o  = (phase == PH_LOW)  && (cnt == lo_mid);
  assign high_mid_o = (phase == PH_HIGH) && (cnt == hi_mid);
endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic scl_o,
  input logic period_o,
  input logic low_mid_o,
  input logic high_mid_o
);
  // R1: a stopped generator rests high and quiet
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (scl_o && !period_o && !low_mid_o && !high_mid_o));

  // R2: start opens a low phase and flags a new period
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |=> (!scl_o && period_o));

  // R5: period strobe only inside the low level
  a_r5_period_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    period_o |-> !scl_o);

  // R3: every falling SCL edge coincides with a period start
  a_r3_fall_is_period: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_o) |-> period_o);

  // R6: sample strobe only while SCL is high
  a_r6_sample_high: assert property (@(posedge clk) disable iff (!rst_n)
    high_mid_o |-> (scl_o && !period_o));

  // R7: update strobe only while SCL is low, never with the period strobe
  a_r7_update_low: assert property (@(posedge clk) disable iff (!rst_n)
    low_mid_o |-> (!scl_o && !period_o));
endmodule

bind scl_phase_gen scl_phase_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .scl_o      (scl_o),
  .period_o   (period_o),
  .low_mid_o  (low_mid_o),
  .high_mid_o (high_mid_o)
);

// File: tb/scl_phase_gen_bench.sv
module scl_phase_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [31:0] div_cfg = '0;
  logic        scl_o, period_o, low_mid_o, high_mid_o;

  int     n_chk = 0;
  int     n_fail = 0;
  longint cyc = 0;
  longint exp_q[$];
  logic   scl_prev = 1'b1;
  bit     done = 0;

  always #10 clk = ~clk;  // 50 MHz

  scl_phase_gen u_scl_phase_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .div_cfg    (div_cfg),
    .scl_o      (scl_o),
    .period_o   (period_o),
    .low_mid_o  (low_mid_o),
    .high_mid_o (high_mid_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // event kinds: 0 period start, 1 low middle, 2 SCL rise, 3 high middle
  function automatic string kind_req(input int k);
    case (k)
      0: return "R5";
      1: return "R7";
      2: return "R3";
      default: return "R6";
    endcase
  endfunction

  function automatic longint lo_len(input logic [31:0] c);
    return 8 * (longint'(c[15:0]) + 1);
  endfunction
  function automatic longint hi_len(input logic [31:0] c);
    return 8 * (longint'(c[31:16]) + 1);
  endfunction

  task automatic push_ev(input longint at, input int k);
    exp_q.push_back(at * 4 + k);
  endtask

  // Expected events of one period starting at cycle t (R3, R4, R6, R7)
  task automatic push_period(input logic [31:0] c, input longint t);
    push_ev(t, 0);
    push_ev(t + lo_len(c) / 2, 1);
    push_ev(t + lo_len(c), 2);
    push_ev(t + lo_len(c) + hi_len(c) / 2, 3);
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: compare observed events with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < 4; k++) begin
        bit hit;
        case (k)
          0: hit = period_o;
          1: hit = low_mid_o;
          2: hit = scl_o && !scl_prev;
          default: hit = high_mid_o;
        endcase
        if (hit) begin
          if (exp_q.size() == 0) begin
            check(0, kind_req(k), cyc * 4 + k, -1);
          end else begin
            longint e;
            e = exp_q.pop_front();
            check(e == cyc * 4 + k, kind_req(k), cyc * 4 + k, e);
          end
        end
      end
    end
    scl_prev = scl_o;
  end

  // R1: idle line is high and quiet for a few cycles
  task automatic idle_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(scl_o == 1'b1, "R1", scl_o, 1);
      check({period_o, low_mid_o, high_mid_o} == 3'b000, "R1",
            {period_o, low_mid_o, high_mid_o}, 0);
    end
  endtask

  // Run one period with cfg a, then nb periods with cfg b (written mid-period, R8)
  task automatic run_seq(input logic [31:0] a, input logic [31:0] b, input int nb);
    longint s, t;
    @(negedge clk);
    s = cyc + 1;      // R2: first low cycle follows the sampling edge
    div_cfg = a;
    run = 1'b1;
    push_period(a, s);
    t = s + lo_len(a) + hi_len(a);
    for (int p = 0; p < nb; p++) begin
      push_period(b, t);
      t = t + lo_len(b) + hi_len(b);
    end
    while (cyc != s + 1) @(negedge clk);
    div_cfg = b;
    while (cyc != t - 1) @(negedge clk);
    run = 1'b0;       // stop on the last high cycle: no extra edge
    idle_check(4);
  endtask

  // R9: abort early in the low phase
  task automatic abort_low(input logic [31:0] a);
    longint s;
    @(negedge clk);
    s = cyc + 1;
    div_cfg = a;
    run = 1'b1;
    push_ev(s, 0);
    push_ev(s + 2, 2);
    while (cyc != s + 1) @(negedge clk);
    run = 1'b0;
    idle_check(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(scl_o == 1'b1, "R1", scl_o, 1);
    check({period_o, low_mid_o, high_mid_o} == 3'b000, "R1",
          {period_o, low_mid_o, high_mid_o}, 0);
    rst_n = 1'b1;
    idle_check(2);

    run_seq(32'h0000_0000, 32'h0000_0000, 2);  // R4: fastest, 16-cycle period
    run_seq(32'h0002_0001, 32'h0002_0001, 2);  // R4/R6: high longer than low
    run_seq(32'h0000_0003, 32'h0000_0003, 1);  // R3/R7: low longer than high
    run_seq(32'h0001_0000, 32'h0000_0002, 2);  // R8: rewrite takes effect next period
    abort_low(32'h0005_0005);                  // R9: abort mid low phase
    run_seq(32'h0003_0001, 32'h0003_0001, 1);  // R9: restart with a fresh word
    run_seq(32'h0028_0064, 32'h0028_0064, 0);  // R3/R4: wide counts

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule